// File: doc/BRIEF.md
# Circular Descriptor-Driven Transfer Channel

This block is one transfer channel that copies a single element from one address to another each time a hardware request arrives. A descriptor sets how the transfer behaves. It holds a start address for reading and one for writing, a signed step added to each address after every element, an element width, a count of elements per pass, and a signed rewind value for each address that is applied when a pass ends.

With these settings the channel can walk a fixed-length list forever. A command list, for example, can be fed into a fixed push register, with the read address stepping by 4 bytes and rewinding by the list length. A fixed pop register can likewise be drained into a ring of 2-byte results, with the write address stepping and rewinding. No processor help is needed once the descriptor is loaded.

The descriptor is written through an 8-entry register port. Data moves over a simple request/acknowledge memory port: one read is followed by one write.

Top module: `dma_ring_channel`

## Requirements
- R1: While reset is held and after it is released with no request seen, `mem_req` and `loop_done` are low.
- R2: Each request produces exactly one memory read at the current read address, followed by exactly one memory write at the current write address that carries the data read.
- R3: After each element, the read address advances by the read step and the write address advances by the write step. Both steps are written with `cfg_sel` codes 2 and 3, and both are added as two's-complement values.
- R4: The remaining count is loaded by writing `cfg_sel` code 5, which also sets the per-pass count. It drops by one per element. After the element that finds it at one, it reloads from the per-pass count.
- R5: On the element that ends a pass, the read rewind (`cfg_sel` code 6) is added to the read address and the write rewind (`cfg_sel` code 7) is added to the write address, in addition to the steps.
- R6: `loop_done` is high for exactly one cycle, in the cycle after the write acknowledge of each pass-ending element, and is low at all other times.
- R7: Requests that arrive while a transfer is busy are counted and served later in order. None is lost while fewer than 2**PW-1 are waiting.
- R8: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we` and `mem_addr` hold their values.
- R9: The element size code (`cfg_sel` code 4) is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. It appears on `mem_size` in both phases. Write data is the read data with every byte above the element size forced to zero.
- R10: Negative steps and positive rewinds work, so that a buffer can be walked downward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor register write strobe |
| cfg_sel | input | 3 | Descriptor register select (0 rd addr, 1 wr addr, 2 rd step, 3 wr step, 4 size, 5 count, 6 rd rewind, 7 wr rewind) |
| cfg_wdata | input | AW | Descriptor write value |
| dreq | input | 1 | Transfer request, one element per cycle high |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write phase, 0 = read phase |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 2 | Element size code |
| mem_wdata | output | DW | Write data, right-aligned |
| mem_rdata | input | DW | Read data, right-aligned |
| mem_ack | input | 1 | Access completes at this clock edge |
| loop_done | output | 1 | One-cycle pulse at the end of each pass |

## Verification
A request pulse is counted at the next edge. The read phase is visible one cycle later. The write phase follows the edge that samples the read acknowledge. The addresses and the count update at the edge that samples the write acknowledge, and `loop_done` is visible during the cycle after that edge. The bench drives every input on the falling edge. It checks each access at the falling edge where it raises the acknowledge, since that access completes at the following rising edge. It checks `loop_done` at exactly the next falling edge after a pass-ending write and nowhere else.

// File: rtl/dma_ring_channel.sv
module dma_ring_channel #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          dreq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          loop_done
);

  localparam logic [PW-1:0] PEND_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t           st_q;
  logic [AW-1:0] rd_addr_q, wr_addr_q, rd_step_q, wr_step_q, rd_rew_q, wr_rew_q;
  logic [1:0]    size_q;
  logic [CW-1:0] per_pass_q, left_q;
  logic [PW-1:0] pend_q;
  logic [DW-1:0] hold_q;
  logic          done_q;
  logic [DW-1:0] lane_mask;
  logic          pass_end, start, finish, take;

  assign lane_mask = (size_q == 2'd0) ? DW'(8'hFF) :
                     (size_q == 2'd1) ? DW'(16'hFFFF) : '1;

  assign pass_end = (left_q <= CW'(1));
  assign start    = (st_q == S_IDLE) && (pend_q != '0);
  assign finish   = (st_q == S_WR) && mem_ack;
  assign take     = dreq && (pend_q != PEND_MAX);

  assign mem_req   = (st_q != S_IDLE);
  assign mem_we    = (st_q == S_WR);
  assign mem_addr  = (st_q == S_WR) ? wr_addr_q : rd_addr_q;
  assign mem_size  = size_q;
  assign mem_wdata = hold_q;
  assign loop_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pend_q <= '0;
      hold_q <= '0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_q + PW'(take) - PW'(start);
      done_q <= finish && pass_end;
      case (st_q)
        S_IDLE: if (start) st_q <= S_RD;
        S_RD: if (mem_ack) begin
          hold_q <= mem_rdata & lane_mask;
          st_q   <= S_WR;
        end
        S_WR: if (mem_ack) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_addr_q  <= '0;
      wr_addr_q  <= '0;
      rd_step_q  <= '0;
      wr_step_q  <= '0;
      rd_rew_q   <= '0;
      wr_rew_q   <= '0;
      size_q     <= 2'd2;
      per_pass_q <= '0;
      left_q     <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: rd_addr_q <= cfg_wdata;
        3'd1: wr_addr_q <= cfg_wdata;
        3'd2: rd_step_q <= cfg_wdata;
        3'd3: wr_step_q <= cfg_wdata;
        3'd4: size_q    <= cfg_wdata[1:0];
        3'd5: begin
          per_pass_q <= cfg_wdata[CW-1:0];
          left_q     <= cfg_wdata[CW-1:0];
        end
        3'd6: rd_rew_q <= cfg_wdata;
        default: wr_rew_q <= cfg_wdata;
      endcase
    end else if (finish) begin
      rd_addr_q <= rd_addr_q + rd_step_q + (pass_end ? rd_rew_q : '0);
      wr_addr_q <= wr_addr_q + wr_step_q + (pass_end ? wr_rew_q : '0);
      left_q    <= pass_end ? per_pass_q : left_q - CW'(1);
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  // R2
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

  // R9
  wdata_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ((mem_wdata & ~lane_mask) == '0));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |=> !loop_done);

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |-> (left_q == per_pass_q));

  // R7
  pend_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && pend_q != '0) |=> mem_req);

endmodule

// File: tb/dma_ring_channel_tb.sv
module dma_ring_channel_tb;
  localparam int AW = 32;
  localparam int DW = 32;

  typedef struct {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [1:0]    size;
    logic          last;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          dreq = 1'b0;
  logic          mem_req, mem_we, loop_done;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ack = 1'b0;

  always #4 clk = ~clk;

  dma_ring_channel #(.AW(AW), .DW(DW), .CW(4), .PW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dreq(dreq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .loop_done(loop_done));

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  int n_wr = 0;
  int n_exp = 0;
  int cyc = 0;
  int wait_n = 0;
  int txn = 0;
  bit in_txn = 0;
  bit exp_done = 0;
  bit ended = 0;
  logic [AW-1:0] held_addr;

  logic [AW-1:0] m_src, m_dst, m_sstep, m_dstep, m_srew, m_drew;
  logic [1:0]    m_size;
  int            m_cnt, m_per;

  function automatic logic [DW-1:0] rd_word(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  function automatic logic [DW-1:0] msk(input logic [1:0] s);
    return (s == 2'd0) ? 32'h0000_00FF : (s == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int sel, input logic [AW-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [AW-1:0] s, input logic [AW-1:0] d,
                       input logic [AW-1:0] ss, input logic [AW-1:0] ds,
                       input logic [1:0] sz, input int n,
                       input logic [AW-1:0] sr, input logic [AW-1:0] dr);
    cfg(0, s); cfg(1, d); cfg(2, ss); cfg(3, ds);
    cfg(4, AW'(sz)); cfg(5, AW'(n)); cfg(6, sr); cfg(7, dr);
    m_src = s; m_dst = d; m_sstep = ss; m_dstep = ds; m_size = sz;
    m_cnt = n; m_per = n; m_srew = sr; m_drew = dr;
  endtask

  // driver: one request pulse, expected item pushed to the scoreboard
  task automatic req(input string tag, input int gap);
    item_t it;
    bit last;
    last = (m_cnt <= 1);
    it.src = m_src; it.dst = m_dst; it.size = m_size; it.last = last; it.tag = tag;
    q.push_back(it);
    n_exp++;
    m_src = m_src + m_sstep + (last ? m_srew : '0);
    m_dst = m_dst + m_dstep + (last ? m_drew : '0);
    m_cnt = last ? m_per : m_cnt - 1;
    @(negedge clk);
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic req_burst(input string tag, input int n);
    item_t it;
    bit last;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      last = (m_cnt <= 1);
      it.src = m_src; it.dst = m_dst; it.size = m_size; it.last = last; it.tag = tag;
      q.push_back(it);
      n_exp++;
      m_src = m_src + m_sstep + (last ? m_srew : '0);
      m_dst = m_dst + m_dstep + (last ? m_drew : '0);
      m_cnt = last ? m_per : m_cnt - 1;
      dreq = 1'b1;
      @(negedge clk);
    end
    dreq = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // memory model and monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_done) begin
        chk(loop_done === 1'b1, "R4 R6 pass-end pulse", 64'(loop_done), 64'd1);
        exp_done = 0;
      end else if (loop_done !== 1'b0) begin
        chk(1'b0, "R6 stray pulse", 64'(loop_done), 64'd0);
      end
      if (mem_ack) begin
        mem_ack = 1'b0;
        in_txn = 0;
      end else if (mem_req) begin
        if (!in_txn) begin
          in_txn = 1;
          held_addr = mem_addr;
          wait_n = txn % 3;
          txn++;
        end else begin
          chk(mem_addr == held_addr, "R8 address hold", 64'(mem_addr), 64'(held_addr));
        end
        if (wait_n == 0) begin
          mem_ack = 1'b1;
          if (q.size() == 0) begin
            chk(1'b0, "R2 R7 unexpected access", 64'(mem_addr), 64'd0);
          end else if (!mem_we) begin
            mem_rdata = rd_word(mem_addr);
            chk(mem_addr == q[0].src, {q[0].tag, " read address"}, 64'(mem_addr), 64'(q[0].src));
            chk(mem_size == q[0].size, "R9 size code on read", 64'(mem_size), 64'(q[0].size));
          end else begin
            chk(mem_addr == q[0].dst, {q[0].tag, " write address"}, 64'(mem_addr), 64'(q[0].dst));
            chk(mem_wdata == (rd_word(q[0].src) & msk(q[0].size)), "R2 R9 write data",
                64'(mem_wdata), 64'(rd_word(q[0].src) & msk(q[0].size)));
            exp_done = q[0].last;
            n_wr++;
            void'(q.pop_front());
          end
        end else begin
          wait_n--;
        end
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !ended) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(mem_req === 1'b0, "R1 mem_req in reset", 64'(mem_req), 64'd0);
    chk(loop_done === 1'b0, "R1 loop_done in reset", 64'(loop_done), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_req === 1'b0 && loop_done === 1'b0, "R1 idle after reset",
        64'({mem_req, loop_done}), 64'd0);

    // command feed: list of 3 words into a fixed push register
    setup(32'h1000, 32'h8000, 32'd4, 32'd0, 2'd2, 3, -32'sd12, 32'd0);
    for (int i = 0; i < 7; i++) req("R3 R5 command feed", 8);
    drain();

    // result drain: fixed pop register into a ring of 8 halfwords, bursts
    setup(32'h9000, 32'h2000, 32'd0, 32'd2, 2'd1, 8, 32'd0, -32'sd16);
    req_burst("R7 R5 result drain", 3);
    req_burst("R7 R5 result drain", 4);
    drain();
    req_burst("R7 R5 result drain", 5);
    drain();

    // downward walk, byte elements
    setup(32'h3010, 32'h4000, -32'sd1, 32'd1, 2'd0, 2, 32'd2, -32'sd2);
    for (int i = 0; i < 5; i++) req("R10 R3 downward walk", 0);
    drain();

    chk(n_wr == n_exp, "R7 every request served", 64'(n_wr), 64'(n_exp));
    chk(q.size() == 0, "R7 scoreboard empty", 64'(q.size()), 64'd0);
    finish_run();
  end
endmodule